// File: doc/BRIEF.md
# Query and ID Response Lane Replicator

This block forms the read word a host sees when it reads a flash bank in query mode or identification mode. The bank is made of several identical devices wired side by side, so each device answers on its own byte lanes. The block scales the host byte address down to a per-device index, looks the index up in a byte-wide query ROM or picks an identification code, and spreads that answer over every device slot of the bank. An access wider than the bank is built by joining several lookups side by side.

Bank width, device width, maximum device width and access width all arrive as base-two logarithms of byte counts. A separate flag selects a legacy path for banks whose device width was never set. That path uses a plain address shift and returns a single table byte or a joined pair of identification registers. The response is registered once, so `rd_data` and `rd_valid` appear in the cycle after `rd_req`.

Top module: `qlr_resp_replicator`

## Requirements
- R1: Reset clears `rd_data` and `rd_valid`. In the cycle after a cycle with `rd_req` high, `rd_valid` is 1 and `rd_data` holds the response. After a cycle with `rd_req` low, `rd_valid` is 0 and `rd_data` keeps its previous value.
- R2: With `dev_unset`=0, each lookup uses the index `addr >> (bank_lg + maxdev_lg - dev_lg)`. If `maxdev_lg < dev_lg`, the whole response is zero.
- R3: A query index of 82 or more gives a zero table byte. Index 81 still reads the ROM.
- R4: In query mode with `dev_lg == maxdev_lg`, byte b of a lookup inside the bank holds the table byte when `b mod 2^dev_lg == 0`, and holds zero otherwise.
- R5: In query mode with `dev_lg != maxdev_lg`, every byte of the bank holds the table byte, provided `dev_lg == 0` and `bank_lg != 3`. Otherwise the lookup is zero.
- R6: In identification mode, the low 8 bits of the index select the code: 0 selects `id_w0`, 1 selects `id_w1`, and any other value gives 0. Byte b of the bank receives byte `(b mod 2^dev_lg)` of the 16-bit code zero-extended.
- R7: The access byte count is `2^acc_lg`, clamped to 4. Lookup k (k = 0, 1, ...) covers addresses while `k * 2^bank_lg` is below the access byte count. It reads at `addr + k * 4^bank_lg` and places its bank-wide result starting at byte `k * 2^bank_lg`.
- R8: With `dev_unset`=0, output bytes at or above the access byte count are zero.
- R9: With `dev_unset`=1 in query mode, the index is `addr[7:0] >> bank_lg`, with no shift when `bank_lg == 3`. The response is the table byte in bits 7:0 and zero above, with no lane joining.
- R10: With `dev_unset`=1 in identification mode, legacy index 0 returns `(id_w0 << 8) | id_w1` and index 1 returns `(id_w2 << 8) | id_w3`. Any other index returns zero.
- R11: The default ROM byte at index k is `(7*k + 17) mod 256`, for k from 0 to 81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_req | input | 1 | Read request; the response registers on this edge |
| rd_id_mode | input | 1 | 0 = query table read, 1 = identification read |
| rd_addr | input | ADDR_W | Host byte address |
| acc_lg | input | 2 | log2 of the access width in bytes |
| bank_lg | input | 2 | log2 of the bank width in bytes |
| dev_lg | input | 2 | log2 of the width at which each device is used |
| maxdev_lg | input | 2 | log2 of the native (maximum) device width |
| dev_unset | input | 1 | 1 selects the legacy path (device width not given) |
| id_w0 | input | 16 | Manufacturer code, and first legacy register |
| id_w1 | input | 16 | Device code, and second legacy register |
| id_w2 | input | 16 | Third legacy register |
| id_w3 | input | 16 | Fourth legacy register |
| rd_data | output | 8*OUT_BYTES | Registered response word |
| rd_valid | output | 1 | High one cycle after a request |

## Verification
The hardest situation to reach is a multi-lookup access in which the lanes land on different table indices and different shifts at the same time. One example is a two-byte bank read four bytes wide, where the second lookup jumps four addresses ahead. A single wrong shift or lane offset there still produces plausible bytes. The stimulus therefore picks addresses whose two lookups fall on table entries with distinct values. It also repeats the wide read in identification mode, where only lanes whose index lands on 0 or 1 are non-zero. A clamped access code of 3 is included to show it matches the four-byte result.

// File: rtl/qlr_pkg.sv
`timescale 1ns/1ps
package qlr_pkg;
   localparam int QLR_TABLE_BYTES = 82;
   localparam int QLR_OUT_BYTES   = 4;

   typedef enum logic {
      QLR_QUERY  = 1'b0,
      QLR_IDREAD = 1'b1
   } qlr_mode_e;

   // Default query ROM image: entry k = (7k + 17) mod 256.
   function automatic logic [8*QLR_TABLE_BYTES-1:0] qlr_default_table();
      logic [8*QLR_TABLE_BYTES-1:0] t;
      t = '0;
      for (int k = 0; k < QLR_TABLE_BYTES; k++) begin
         t[8*k +: 8] = 8'((k * 7 + 17) % 256);
      end
      return t;
   endfunction
endpackage

// File: rtl/qlr_query_rom.sv
`timescale 1ns/1ps
module qlr_query_rom #(
   parameter int ENTRIES = 82,
   parameter int IDX_W   = 16,
   parameter logic [8*ENTRIES-1:0] CONTENT = '0
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       data
);
   localparam int SEL_W = $clog2(ENTRIES);

   generate
      if (IDX_W <= SEL_W) begin : g_bad_idx
         $error("qlr_query_rom: IDX_W must exceed the ROM select width");
      end
   endgenerate

   logic [7:0] rom [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_rom
         assign rom[e] = CONTENT[8*e +: 8];
      end
   endgenerate

   logic in_range;
   assign in_range = (idx < IDX_W'(ENTRIES));
   assign data     = in_range ? rom[idx[SEL_W-1:0]] : 8'h00;
endmodule

// File: rtl/qlr_lookup.sv
`timescale 1ns/1ps
module qlr_lookup #(
   parameter int ADDR_W    = 16,
   parameter int OUT_BYTES = 4,
   parameter int TBL_BYTES = 82,
   parameter logic [8*TBL_BYTES-1:0] TBL = '0
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   id_mode,
   input  logic [1:0]             bank_lg,
   input  logic [1:0]             dev_lg,
   input  logic [1:0]             maxdev_lg,
   input  logic [15:0]            id_mfr,
   input  logic [15:0]            id_part,
   output logic [8*OUT_BYTES-1:0] resp
);
   import qlr_pkg::*;

   logic             cfg_bad;
   logic [2:0]       shamt;
   logic [ADDR_W-1:0] idx;
   logic [7:0]       tbyte;
   logic [15:0]      code;
   logic             byte_mode;
   logic             byte_mode_ok;
   logic [3:0]       bank_bytes;
   logic [3:0]       slot_mask;
   qlr_mode_e        mode;

   assign mode      = qlr_mode_e'(id_mode);
   assign cfg_bad   = (maxdev_lg < dev_lg);
   assign shamt     = 3'(bank_lg) + 3'(maxdev_lg) - 3'(dev_lg);
   assign idx       = addr >> shamt;
   assign byte_mode = (maxdev_lg != dev_lg);
   assign byte_mode_ok = (dev_lg == 2'd0) && (bank_lg != 2'd3);
   assign bank_bytes = 4'd1 << bank_lg;
   assign slot_mask  = (4'd1 << dev_lg) - 4'd1;

   qlr_query_rom #(
      .ENTRIES (TBL_BYTES),
      .IDX_W   (ADDR_W),
      .CONTENT (TBL)
   ) i_rom (
      .idx  (idx),
      .data (tbyte)
   );

   always_comb begin
      case (idx[7:0])
         8'd0:    code = id_mfr;
         8'd1:    code = id_part;
         default: code = 16'h0000;
      endcase
   end

   generate
      for (genvar b = 0; b < OUT_BYTES; b++) begin : g_byte
         localparam logic [3:0] BPOS = 4'(b);
         logic [3:0] slot;
         logic [7:0] qv;
         logic [7:0] iv;
         assign slot = BPOS & slot_mask;
         assign qv = byte_mode ? (byte_mode_ok ? tbyte : 8'h00)
                               : ((slot == 4'd0) ? tbyte : 8'h00);
         assign iv = (slot == 4'd0) ? code[7:0] :
                     (slot == 4'd1) ? code[15:8] : 8'h00;
         assign resp[8*b +: 8] = (!cfg_bad && (BPOS < bank_bytes)) ?
                                 ((mode == QLR_IDREAD) ? iv : qv) : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/qlr_lane_join.sv
`timescale 1ns/1ps
module qlr_lane_join #(
   parameter int OUT_BYTES = 4,
   parameter bit WIDE_JOIN = 1'b1
) (
   input  logic [OUT_BYTES-1:0][8*OUT_BYTES-1:0] lanes,
   input  logic [1:0]                            bank_lg,
   input  logic [3:0]                            acc_bytes,
   output logic [8*OUT_BYTES-1:0]                data
);
   generate
      if (WIDE_JOIN) begin : g_join
         always_comb begin
            data = '0;
            for (int j = 0; j < OUT_BYTES; j++) begin
               int k;
               int o;
               k = j >> bank_lg;
               o = j & ((1 << bank_lg) - 1);
               if (j < int'(acc_bytes)) begin
                  data[8*j +: 8] = lanes[k][8*o +: 8];
               end
            end
         end
      end else begin : g_single
         always_comb begin
            data = '0;
            for (int j = 0; j < OUT_BYTES; j++) begin
               if (j < int'(acc_bytes)) begin
                  data[8*j +: 8] = lanes[0][8*j +: 8];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qlr_resp_replicator.sv
`timescale 1ns/1ps
module qlr_resp_replicator #(
   parameter int ADDR_W    = 16,
   parameter int OUT_BYTES = qlr_pkg::QLR_OUT_BYTES,
   parameter int TBL_BYTES = qlr_pkg::QLR_TABLE_BYTES,
   parameter logic [8*TBL_BYTES-1:0] TBL = qlr_pkg::qlr_default_table(),
   parameter bit WIDE_JOIN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_req,
   input  logic                   rd_id_mode,
   input  logic [ADDR_W-1:0]      rd_addr,
   input  logic [1:0]             acc_lg,
   input  logic [1:0]             bank_lg,
   input  logic [1:0]             dev_lg,
   input  logic [1:0]             maxdev_lg,
   input  logic                   dev_unset,
   input  logic [15:0]            id_w0,
   input  logic [15:0]            id_w1,
   input  logic [15:0]            id_w2,
   input  logic [15:0]            id_w3,
   output logic [8*OUT_BYTES-1:0] rd_data,
   output logic                   rd_valid
);
   localparam int OUT_W = 8 * OUT_BYTES;

   generate
      if (OUT_BYTES < 4 || OUT_BYTES > 8) begin : g_bad_out
         $error("qlr_resp_replicator: OUT_BYTES must be 4 to 8");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("qlr_resp_replicator: ADDR_W must be at least 9");
      end
   endgenerate

   // ---------------- device-width path ----------------
   logic [3:0] acc_raw;
   logic [3:0] acc_bytes;
   logic [2:0] lane_step_sh;
   logic [OUT_BYTES-1:0][OUT_W-1:0] lane_resp;
   logic [OUT_W-1:0] joined;

   assign acc_raw      = 4'd1 << acc_lg;
   assign acc_bytes    = (acc_raw > 4'(OUT_BYTES)) ? 4'(OUT_BYTES) : acc_raw;
   assign lane_step_sh = {bank_lg, 1'b0};

   generate
      for (genvar k = 0; k < OUT_BYTES; k++) begin : g_lane
         logic [ADDR_W-1:0] lane_addr;
         assign lane_addr = rd_addr + (ADDR_W'(k) << lane_step_sh);
         qlr_lookup #(
            .ADDR_W    (ADDR_W),
            .OUT_BYTES (OUT_BYTES),
            .TBL_BYTES (TBL_BYTES),
            .TBL       (TBL)
         ) i_lookup (
            .addr      (lane_addr),
            .id_mode   (rd_id_mode),
            .bank_lg   (bank_lg),
            .dev_lg    (dev_lg),
            .maxdev_lg (maxdev_lg),
            .id_mfr    (id_w0),
            .id_part   (id_w1),
            .resp      (lane_resp[k])
         );
      end
   endgenerate

   qlr_lane_join #(
      .OUT_BYTES (OUT_BYTES),
      .WIDE_JOIN (WIDE_JOIN)
   ) i_join (
      .lanes     (lane_resp),
      .bank_lg   (bank_lg),
      .acc_bytes (acc_bytes),
      .data      (joined)
   );

   // ---------------- legacy path ----------------
   logic [1:0]        lg_sh;
   logic [7:0]        lg_low;
   logic [ADDR_W-1:0] lg_idx;
   logic [7:0]        lg_tbyte;
   logic [OUT_W-1:0]  lg_query;
   logic [OUT_W-1:0]  lg_ident;

   assign lg_sh  = (bank_lg == 2'd3) ? 2'd0 : bank_lg;
   assign lg_low = rd_addr[7:0] >> lg_sh;
   assign lg_idx = {{(ADDR_W-8){1'b0}}, lg_low};

   qlr_query_rom #(
      .ENTRIES (TBL_BYTES),
      .IDX_W   (ADDR_W),
      .CONTENT (TBL)
   ) i_legacy_rom (
      .idx  (lg_idx),
      .data (lg_tbyte)
   );

   assign lg_query = {{(OUT_W-8){1'b0}}, lg_tbyte};

   always_comb begin
      case (lg_low)
         8'd0:    lg_ident = (OUT_W'(id_w0) << 8) | OUT_W'(id_w1);
         8'd1:    lg_ident = (OUT_W'(id_w2) << 8) | OUT_W'(id_w3);
         default: lg_ident = '0;
      endcase
   end

   // ---------------- output register ----------------
   logic [OUT_W-1:0] next_data;
   assign next_data = dev_unset ? (rd_id_mode ? lg_ident : lg_query) : joined;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_data <= next_data;
         end
      end
   end

   // ---------------- assertions ----------------
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (!rd_valid && $stable(rd_data)));

   p_bad_cfg_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !dev_unset && (maxdev_lg < dev_lg)) |=> (rd_data == '0));

   p_x8_unsupported_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !dev_unset && !rd_id_mode && (maxdev_lg > dev_lg) && (dev_lg != 2'd0))
      |=> (rd_data == '0));

   p_acc_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !dev_unset && (acc_lg == 2'd0)) |=> (rd_data[OUT_W-1:8] == '0));

   p_legacy_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && dev_unset && !rd_id_mode) |=> (rd_data[OUT_W-1:8] == '0));
endmodule

// File: tb/test_qlr_resp_replicator.sv
`timescale 1ns/1ps
module test_qlr_resp_replicator;
   localparam logic [15:0] W0 = 16'h12AB;
   localparam logic [15:0] W1 = 16'h34CD;
   localparam logic [15:0] W2 = 16'h0056;
   localparam logic [15:0] W3 = 16'h00EF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rd_req;
   logic        rd_id_mode;
   logic [15:0] rd_addr;
   logic [1:0]  acc_lg, bank_lg, dev_lg, maxdev_lg;
   logic        dev_unset;
   logic [31:0] rd_data;
   logic        rd_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   qlr_resp_replicator i_qlr_resp_replicator (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_id_mode(rd_id_mode),
      .rd_addr(rd_addr), .acc_lg(acc_lg), .bank_lg(bank_lg), .dev_lg(dev_lg),
      .maxdev_lg(maxdev_lg), .dev_unset(dev_unset),
      .id_w0(W0), .id_w1(W1), .id_w2(W2), .id_w3(W3),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // ---------------- reference model from the requirements ----------------
   function automatic logic [7:0] tbl(int k);
      return 8'((k * 7 + 17) % 256);
   endfunction

   function automatic logic [31:0] m_lookup(int addr, bit idm, int bl, int dl, int ml);
      logic [31:0] r;
      logic [7:0]  tb;
      logic [15:0] code;
      int sh, idx, bb, db;
      r = '0;
      if (ml < dl) return r;
      sh  = bl + ml - dl;
      idx = addr >> sh;
      tb  = (idx < 82) ? tbl(idx) : 8'h00;
      code = ((idx & 255) == 0) ? W0 : (((idx & 255) == 1) ? W1 : 16'h0);
      bb = 1 << bl;
      db = 1 << dl;
      for (int b = 0; b < 4 && b < bb; b++) begin
         int s;
         logic [7:0] v;
         s = b % db;
         if (idm) v = (s == 0) ? code[7:0] : ((s == 1) ? code[15:8] : 8'h00);
         else if (ml != dl) v = (dl == 0 && bl != 3) ? tb : 8'h00;
         else v = (s == 0) ? tb : 8'h00;
         r[8*b +: 8] = v;
      end
      return r;
   endfunction

   function automatic logic [31:0] m_dev(int addr, bit idm, int bl, int dl, int ml, int al);
      logic [31:0] r;
      int accb, bb;
      r = '0;
      accb = ((1 << al) > 4) ? 4 : (1 << al);
      bb = 1 << bl;
      for (int k = 0; k * bb < accb; k++) begin
         logic [31:0] lk;
         lk = m_lookup((addr + k * bb * bb) & 16'hFFFF, idm, bl, dl, ml);
         for (int o = 0; o < bb; o++) begin
            int j;
            j = k * bb + o;
            if (j < accb && j < 4) r[8*j +: 8] = lk[8*o +: 8];
         end
      end
      return r;
   endfunction

   function automatic logic [31:0] m_legacy(int addr, bit idm, int bl);
      int sh, idx;
      sh  = (bl == 3) ? 0 : bl;
      idx = (addr & 255) >> sh;
      if (!idm) return (idx < 82) ? {24'h0, tbl(idx)} : 32'h0;
      if (idx == 0) return ({16'h0, W0} << 8) | {16'h0, W1};
      if (idx == 1) return ({16'h0, W2} << 8) | {16'h0, W3};
      return 32'h0;
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic issue(int addr, bit idm, int bl, int dl, int ml, int al, bit unset);
      @(negedge clk);
      rd_addr = 16'(addr); rd_id_mode = idm;
      bank_lg = 2'(bl); dev_lg = 2'(dl); maxdev_lg = 2'(ml); acc_lg = 2'(al);
      dev_unset = unset;
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic rd_chk(string req, int addr, bit idm, int bl, int dl, int ml, int al, bit unset);
      logic [31:0] exp;
      exp = unset ? m_legacy(addr, idm, bl) : m_dev(addr, idm, bl, dl, ml, al);
      issue(addr, idm, bl, dl, ml, al, unset);
      check(req, rd_data, exp);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check("R1 reset data", rd_data, 32'h0);
      check("R1 reset valid", {31'h0, rd_valid}, 32'h0);
   endtask

   task automatic t_latency();
      logic [31:0] held;
      issue(16'h0010, 1'b0, 0, 0, 0, 0, 1'b0);
      check("R1 valid after request", {31'h0, rd_valid}, 32'h1);
      check("R1 data after request", rd_data, {24'h0, tbl(16)});
      held = rd_data;
      rd_addr = 16'h0020;
      @(negedge clk);
      check("R1 valid drops when idle", {31'h0, rd_valid}, 32'h0);
      check("R1 data held when idle", rd_data, held);
   endtask

   task automatic t_native_query();
      rd_chk("R4 bank1 dev1", 16'h0005, 1'b0, 0, 0, 0, 0, 1'b0);
      rd_chk("R4 bank4 dev2", 16'h0040, 1'b0, 2, 1, 1, 2, 1'b0);
      rd_chk("R4 bank4 dev4", 16'h0024, 1'b0, 2, 2, 2, 2, 1'b0);
      rd_chk("R2 shift bank2 dev2", 16'h0044, 1'b0, 1, 1, 1, 1, 1'b0);
      rd_chk("R11 table entry 0", 16'h0000, 1'b0, 0, 0, 0, 0, 1'b0);
      rd_chk("R11 table entry 0x51", 16'h0051, 1'b0, 0, 0, 0, 0, 1'b0);
   endtask

   task automatic t_range();
      rd_chk("R3 index 81", 16'h0051, 1'b0, 0, 0, 0, 0, 1'b0);
      rd_chk("R3 index 82", 16'h0052, 1'b0, 0, 0, 0, 0, 1'b0);
      rd_chk("R3 index 200", 16'h00C8, 1'b0, 0, 0, 0, 0, 1'b0);
      rd_chk("R3 bank4 index 82", 16'd328, 1'b0, 2, 2, 2, 2, 1'b0);
      rd_chk("R3 bank4 index 81", 16'd324, 1'b0, 2, 2, 2, 2, 1'b0);
   endtask

   task automatic t_byte_mode();
      rd_chk("R5 x8 of x16 bank2", 16'h0048, 1'b0, 1, 0, 1, 1, 1'b0);
      rd_chk("R5 x8 of x32 bank4", 16'h0150, 1'b0, 2, 0, 2, 2, 1'b0);
      rd_chk("R5 unsupported dev2 in x32", 16'h0040, 1'b0, 2, 1, 2, 2, 1'b0);
      rd_chk("R5 unsupported bank8", 16'h0040, 1'b0, 3, 0, 1, 2, 1'b0);
      rd_chk("R2 maxdev below dev", 16'h0010, 1'b0, 2, 2, 1, 2, 1'b0);
   endtask

   task automatic t_ident();
      rd_chk("R6 index0 byte bank", 16'h0000, 1'b1, 0, 0, 0, 0, 1'b0);
      rd_chk("R6 index1 byte bank", 16'h0001, 1'b1, 0, 0, 0, 0, 1'b0);
      rd_chk("R6 index2 zero", 16'h0002, 1'b1, 0, 0, 0, 0, 1'b0);
      rd_chk("R6 low8 wrap to 0", 16'h0100, 1'b1, 0, 0, 0, 0, 1'b0);
      rd_chk("R6 dev2 slots bank4", 16'h0000, 1'b1, 2, 1, 1, 2, 1'b0);
      rd_chk("R6 dev4 bank4", 16'h0004, 1'b1, 2, 2, 2, 2, 1'b0);
      rd_chk("R6 dev1 bank4", 16'h0004, 1'b1, 2, 0, 0, 2, 1'b0);
   endtask

   task automatic t_wide();
      rd_chk("R7 bank1 four lanes", 16'h0010, 1'b0, 0, 0, 0, 2, 1'b0);
      rd_chk("R7 bank2 two lanes", 16'h0020, 1'b0, 1, 1, 1, 2, 1'b0);
      rd_chk("R7 bank2 x8 two lanes", 16'h0030, 1'b0, 1, 0, 1, 2, 1'b0);
      rd_chk("R7 ident four lanes", 16'h0000, 1'b1, 0, 0, 0, 2, 1'b0);
      rd_chk("R7 access code 3 clamps", 16'h0010, 1'b0, 0, 0, 0, 3, 1'b0);
   endtask

   task automatic t_mask();
      rd_chk("R8 bank4 byte access", 16'h0000, 1'b0, 2, 0, 0, 0, 1'b0);
      rd_chk("R8 bank4 half access ident", 16'h0000, 1'b1, 2, 2, 2, 1, 1'b0);
      rd_chk("R8 bank2 byte access", 16'h0012, 1'b0, 1, 0, 0, 0, 1'b0);
   endtask

   task automatic t_legacy();
      rd_chk("R9 legacy bank2", 16'h0020, 1'b0, 1, 0, 0, 2, 1'b1);
      rd_chk("R9 legacy beyond table", 16'h00FF, 1'b0, 0, 0, 0, 2, 1'b1);
      rd_chk("R9 legacy upper bits ignored", 16'h01A4, 1'b0, 2, 0, 0, 2, 1'b1);
      rd_chk("R9 legacy bank8 unshifted", 16'h0030, 1'b0, 3, 0, 0, 2, 1'b1);
      rd_chk("R10 legacy index0", 16'h0000, 1'b1, 1, 0, 0, 2, 1'b1);
      rd_chk("R10 legacy index1", 16'h0002, 1'b1, 1, 0, 0, 2, 1'b1);
      rd_chk("R10 legacy index2", 16'h0004, 1'b1, 1, 0, 0, 2, 1'b1);
   endtask

   initial begin
      rst_n = 1'b0; rd_req = 1'b0; rd_id_mode = 1'b0; rd_addr = '0;
      acc_lg = '0; bank_lg = '0; dev_lg = '0; maxdev_lg = '0; dev_unset = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_latency();
      t_native_query();
      t_range();
      t_byte_mode();
      t_ident();
      t_wide();
      t_mask();
      t_legacy();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule